// File: doc/BRIEF.md
# NOR Flash Erase Command Decoder

This block models the command state machine of a parallel NOR flash, reduced to the erase commands. It watches single-cycle write strobes carrying an address and a data byte. It recognises the six-write pattern of unlock, setup, unlock and command that starts either a whole-chip erase or a sector erase. For sector erase it keeps a timed acceptance window open, and further sector commands can join the pending set during that window. When the window closes, or as soon as a chip erase is recognised, a built-in erase phase runs without help from the host. It first drives the selected region to zero, then erases it.

While the erase phase runs, the block raises `busy` and presents the chosen sectors as a bitmap for a memory model. Any write seen in that time is ignored. The synchronous active-low reset also acts as the hardware reset. It stops an erase at once and returns to read mode. When the erase finishes, the pending sector set is cleared, so the next command starts from nothing.

Top module: `nor_erase_ctrl`

## Requirements
- R1: While and after reset `busy`, `prog_zero`, `erase_on`, `window_open` and `erase_req` are all 0. Asserting reset during an erase drops all of them on the next clock edge.
- R2: The six writes AA@0x555, 55@0x2AA, 80@0x555, AA@0x555, 55@0x2AA and 10@0x555 start a chip erase on the sixth write's edge. Unlock addresses are compared over all address bits, with upper bits zero. During the erase `erase_req` is all ones.
- R3: A write with a wrong address or wrong data at any of the six positions returns the decoder to read mode. No window opens and no erase starts, and a correct sequence written next is recognised.
- R4: A sixth write of data 0x30 at any address opens the acceptance window. The sector index is the top SECT_W bits of that address. `busy` stays 0 while the window is open.
- R5: With no further writes, the erase starts exactly WIN_CYC cycles after the edge of the last accepted sector command.
- R6: Each further 0x30 write inside the window adds its sector to the set, in any order, and restarts the WIN_CYC count.
- R7: Inside the window, a write of 0xB0 neither aborts the window, adds a sector nor restarts the count. Any other write that is not 0x30 closes the window and discards the set, and no erase follows.
- R8: An erase shows `prog_zero` for PREP_CYC cycles and then `erase_on` for ERASE_CYC cycles. `busy` is high throughout, and `erase_req` holds the selected set.
- R9: Writes during an erase change neither `erase_req` nor the erase length.
- R10: After an erase, `busy` and `erase_req` are 0. A new sector erase selects only its own sectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset and hardware reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| busy | output | 1 | Erase phase running |
| prog_zero | output | 1 | Preprogram-to-zero part of the erase |
| erase_on | output | 1 | Erase part |
| window_open | output | 1 | Sector acceptance window open |
| erase_req | output | 2**SECT_W | Selected sectors, valid while busy |

## Verification
On every cycle, assertions check the following:
- the selected set is non-empty and stable for the whole erase;
- the window and the erase never overlap;
- the preprogram part hands over only to the erase part;
- the window counter stays within range.

Only the bench scenarios can show the rest:
- exact window and phase lengths;
- the timer restart on each extra sector;
- rejection of each corrupted prefix position;
- the abort-versus-suspend distinction;
- clearing of the set between commands.

// File: rtl/nec_pkg.sv
// Package for the erase command decoder: decoder states and command bytes.
// Assumes byte-wide command data.
package nec_pkg;
    typedef enum logic [2:0] {
        ST_READ, ST_UL1, ST_UL2, ST_SETUP, ST_UL3, ST_UL4, ST_WINDOW, ST_BUSY
    } dec_state_t;

    typedef enum logic [1:0] {PH_IDLE, PH_PREP, PH_ERASE} phase_t;

    localparam logic [10:0] KEY_ADDR_A = 11'h555;
    localparam logic [10:0] KEY_ADDR_B = 11'h2AA;
    localparam logic [7:0]  KEY_DATA_A = 8'hAA;
    localparam logic [7:0]  KEY_DATA_B = 8'h55;
    localparam logic [7:0]  CMD_SETUP  = 8'h80;
    localparam logic [7:0]  CMD_CHIP   = 8'h10;
    localparam logic [7:0]  CMD_SECTOR = 8'h30;
    localparam logic [7:0]  CMD_HOLD   = 8'hB0;
endpackage

// File: rtl/nec_win_timer.sv
// Acceptance window countdown. It reloads to WIN_CYC-1 on load and counts down to zero.
// Assumes WIN_CYC >= 2. The zero flag is meaningful only while the window is open.
module nec_win_timer #(
    parameter int WIN_CYC = 6250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic at_zero
);
    localparam int CW = $clog2(WIN_CYC);
    localparam logic [CW-1:0] LIM = CW'(WIN_CYC - 1);

    logic [CW-1:0] cnt;

    // Reload on an accepted sector command, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= LIM;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign at_zero = (cnt == '0);

    // R5
    win_range_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= LIM);
endmodule

// File: rtl/nec_erase_seq.sv
// Embedded erase sequencer. A start pulse runs PREP_CYC cycles of preprogram, then ERASE_CYC cycles of erase.
// Assumes start arrives only while idle. Synchronous reset aborts at once.
module nec_erase_seq
    import nec_pkg::*;
#(
    parameter int PREP_CYC  = 64,
    parameter int ERASE_CYC = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic prog_zero,
    output logic erase_on,
    output logic done
);
    localparam int MAXC = (PREP_CYC > ERASE_CYC) ? PREP_CYC : ERASE_CYC;
    localparam int PW   = $clog2(MAXC + 1);

    phase_t        phase;
    logic [PW-1:0] cnt;

    // Step through idle, preprogram and erase, with the counter timing each part.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    phase <= PH_PREP;
                    cnt   <= PW'(PREP_CYC - 1);
                end
                PH_PREP: if (cnt == '0) begin
                    phase <= PH_ERASE;
                    cnt   <= PW'(ERASE_CYC - 1);
                end else cnt <= cnt - 1'b1;
                PH_ERASE: if (cnt == '0) phase <= PH_IDLE;
                          else cnt <= cnt - 1'b1;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign prog_zero = (phase == PH_PREP);
    assign erase_on  = (phase == PH_ERASE);
    assign done      = erase_on && (cnt == '0);

    // R8
    prep_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_zero |=> (prog_zero || erase_on));
    // R8
    erase_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_on |=> (erase_on || !prog_zero));
endmodule

// File: rtl/nec_sector_map.sv
// Pending-sector bitmap. Bits can be set one at a time or all together, and cleared together.
// Assumes clear has priority over any set in the same cycle.
module nec_sector_map #(
    parameter int SECT_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 set_all,
    input  logic                 set_en,
    input  logic [SECT_W-1:0]    set_idx,
    output logic [2**SECT_W-1:0] map
);
    localparam int NSECT = 2**SECT_W;

    for (genvar g = 0; g < NSECT; g++) begin : g_bit
        // One pending flag per sector.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)                           map[g] <= 1'b0;
            else if (set_all)                            map[g] <= 1'b1;
            else if (set_en && set_idx == SECT_W'(g))    map[g] <= 1'b1;
        end
    end
endmodule

// File: rtl/nor_erase_ctrl.sv
// Erase command decoder top. It decodes the six-write erase prefix, runs the sector acceptance window
// and hands over to the erase sequencer.
// Assumes ADDR_W >= 11 and that the sector index is the top SECT_W address bits.
module nor_erase_ctrl
    import nec_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int SECT_W    = 3,
    parameter int CLK_MHZ   = 125,
    parameter int WIN_US    = 50,
    parameter int WIN_CYC   = CLK_MHZ * WIN_US,
    parameter int PREP_CYC  = 64,
    parameter int ERASE_CYC = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [7:0]           wr_data,
    output logic                 busy,
    output logic                 prog_zero,
    output logic                 erase_on,
    output logic                 window_open,
    output logic [2**SECT_W-1:0] erase_req
);
    localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(KEY_ADDR_A);
    localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(KEY_ADDR_B);

    dec_state_t            state, nxt;
    logic                  set_all, set_en, map_clr, tmr_load, eng_start;
    logic                  tmr_zero, eng_done;
    logic [2**SECT_W-1:0]  map;
    logic [SECT_W-1:0]     sect_idx;

    assign sect_idx = wr_addr[ADDR_W-1 -: SECT_W];

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        return wr_en && (wr_addr == a) && (wr_data == d);
    endfunction

    // Next-state and control decode for the command sequence.
    always_comb begin
        nxt       = state;
        set_all   = 1'b0;
        set_en    = 1'b0;
        map_clr   = 1'b0;
        tmr_load  = 1'b0;
        eng_start = 1'b0;
        case (state)
            ST_READ:  if (hit(ADR_A, KEY_DATA_A)) nxt = ST_UL1;
            ST_UL1:   if (wr_en) nxt = hit(ADR_B, KEY_DATA_B) ? ST_UL2   : ST_READ;
            ST_UL2:   if (wr_en) nxt = hit(ADR_A, CMD_SETUP)  ? ST_SETUP : ST_READ;
            ST_SETUP: if (wr_en) nxt = hit(ADR_A, KEY_DATA_A) ? ST_UL3   : ST_READ;
            ST_UL3:   if (wr_en) nxt = hit(ADR_B, KEY_DATA_B) ? ST_UL4   : ST_READ;
            ST_UL4: if (wr_en) begin
                if (hit(ADR_A, CMD_CHIP)) begin
                    set_all   = 1'b1;
                    eng_start = 1'b1;
                    nxt       = ST_BUSY;
                end else if (wr_data == CMD_SECTOR) begin
                    set_en   = 1'b1;
                    tmr_load = 1'b1;
                    nxt      = ST_WINDOW;
                end else nxt = ST_READ;
            end
            ST_WINDOW: begin
                if (wr_en && wr_data == CMD_SECTOR) begin
                    set_en   = 1'b1;
                    tmr_load = 1'b1;
                end else if (wr_en && wr_data != CMD_HOLD) begin
                    map_clr = 1'b1;
                    nxt     = ST_READ;
                end else if (tmr_zero) begin
                    eng_start = 1'b1;
                    nxt       = ST_BUSY;
                end
            end
            ST_BUSY: if (eng_done) begin
                map_clr = 1'b1;
                nxt     = ST_READ;
            end
            default: nxt = ST_READ;
        endcase
    end

    // State register; hardware reset returns to read mode.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_READ;
        else        state <= nxt;
    end

    nec_win_timer #(.WIN_CYC(WIN_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .at_zero(tmr_zero)
    );

    nec_sector_map #(.SECT_W(SECT_W)) u_map (
        .clk(clk), .rst_n(rst_n), .clr(map_clr), .set_all(set_all),
        .set_en(set_en), .set_idx(sect_idx), .map(map)
    );

    nec_erase_seq #(.PREP_CYC(PREP_CYC), .ERASE_CYC(ERASE_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(eng_start),
        .prog_zero(prog_zero), .erase_on(erase_on), .done(eng_done)
    );

    assign busy        = prog_zero || erase_on;
    assign window_open = (state == ST_WINDOW);
    assign erase_req   = busy ? map : '0;

    // R2 R4
    busy_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (erase_req != '0));
    // R7
    window_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        window_open |-> !busy);
    // R9
    ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(erase_req)));
endmodule

// File: tb/nor_erase_ctrl_tb.sv
`timescale 1ns/1ps
module nor_erase_ctrl_tb;
    localparam int AW = 12, SW = 3, NS = 8, WIN = 8, PREP = 4, ERS = 6;
    localparam logic [NS-1:0] ALL = '1;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic busy, prog_zero, erase_on, window_open;
    logic [NS-1:0] erase_req;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    nor_erase_ctrl #(.ADDR_W(AW), .SECT_W(SW), .WIN_CYC(WIN), .PREP_CYC(PREP), .ERASE_CYC(ERS)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .prog_zero(prog_zero), .erase_on(erase_on),
        .window_open(window_open), .erase_req(erase_req)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [AW-1:0] sa(input int s);
        return {3'(s), 9'h1C3};
    endfunction

    function automatic logic [AW-1:0] pa(input int p);
        return (p == 1 || p == 4) ? 12'h2AA : 12'h555;
    endfunction

    function automatic logic [7:0] pd(input int p);
        case (p)
            0, 3: return 8'hAA;
            1, 4: return 8'h55;
            2:    return 8'h80;
            default: return 8'h10;
        endcase
    endfunction

    task automatic prefix5();
        for (int p = 0; p < 5; p++) wr(pa(p), pd(p));
    endtask

    // R8 phase lengths and map; R10 clean end
    task automatic phases(input logic [NS-1:0] m);
        for (int i = 0; i < PREP; i++) begin
            check(busy && prog_zero && !erase_on && erase_req == m, "R8 prep", {busy, prog_zero, erase_on, erase_req}, {3'b110, m});
            @(negedge clk);
        end
        for (int i = 0; i < ERS; i++) begin
            check(busy && !prog_zero && erase_on && erase_req == m, "R8 erase", {busy, prog_zero, erase_on, erase_req}, {3'b101, m});
            @(negedge clk);
        end
        check(!busy && erase_req == '0 && !window_open, "R10 idle", {busy, erase_req}, 0);
    endtask

    // R5 window stays open for n more cycles, then the erase starts
    task automatic expire(input int n, input logic [NS-1:0] m);
        for (int i = 0; i < n; i++) begin
            check(window_open && !busy, "R5 open", {window_open, busy}, 2);
            @(negedge clk);
        end
        check(busy && !window_open, "R5 start", {busy, window_open}, 2);
        phases(m);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !prog_zero && !erase_on && !window_open && erase_req == '0, "R1 reset", {busy, window_open, erase_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !window_open && erase_req == '0, "R1 after reset", {busy, window_open}, 0);

        // R2 chip erase
        prefix5(); wr(12'h555, 8'h10);
        check(busy, "R2 chip start", busy, 1);
        phases(ALL);

        // R3 corrupted data or address at each position
        for (int p = 0; p < 6; p++) begin
            for (int k = 0; k < 2; k++) begin
                for (int q = 0; q < p; q++) wr(pa(q), pd(q));
                if (k == 0) wr(pa(p), pd(p) ^ 8'h01);
                else        wr(pa(p) ^ 12'h001, pd(p));
                repeat (2) @(negedge clk);
                check(!busy && !window_open, "R3 reject", {busy, window_open}, 0);
                prefix5(); wr(12'h555, 8'h10);
                check(busy && erase_req == ALL, "R3 recover", erase_req, ALL);
                phases(ALL);
            end
        end

        // R4 each sector alone
        for (int s = 0; s < NS; s++) begin
            prefix5(); wr(sa(s), 8'h30);
            check(window_open && !busy && erase_req == '0, "R4 window", {window_open, busy, erase_req}, 4'h8 << 4);
            expire(WIN, NS'(1) << s);
        end

        // R6 descending order with restart of the count
        prefix5(); wr(sa(5), 8'h30);
        repeat (5) @(negedge clk);
        wr(sa(1), 8'h30);
        repeat (6) @(negedge clk);
        wr(sa(0), 8'h30);
        expire(WIN, 8'b0010_0011);

        // R7 abort by another command
        prefix5(); wr(sa(2), 8'h30);
        wr(sa(6), 8'hF0);
        check(!window_open && !busy, "R7 abort", {window_open, busy}, 0);
        repeat (WIN + 2) @(negedge clk);
        check(!busy && erase_req == '0, "R7 no erase", {busy, erase_req}, 0);

        // R7 suspend byte neither aborts, adds nor restarts
        prefix5(); wr(sa(3), 8'h30);
        repeat (3) @(negedge clk);
        wr(sa(6), 8'hB0);
        expire(WIN - 4, 8'b0000_1000);

        // R9 writes during erase ignored
        prefix5(); wr(sa(1), 8'h30);
        repeat (WIN) @(negedge clk);
        check(busy, "R9 start", busy, 1);
        wr(12'h555, 8'hAA); wr(sa(7), 8'h30);
        repeat (PREP + ERS - 3) begin
            check(busy && erase_req == 8'h02, "R9 hold", erase_req, 2);
            @(negedge clk);
        end
        check(busy, "R9 last", busy, 1);
        @(negedge clk);
        check(!busy && erase_req == '0, "R9 end", busy, 0);

        // R10 no carry-over of the previous set
        prefix5(); wr(sa(0), 8'h30);
        expire(WIN, 8'b0000_0001);

        // R1 hardware reset during erase
        prefix5(); wr(12'h555, 8'h10);
        repeat (PREP + 1) @(negedge clk);
        check(erase_on, "R1 mid erase", erase_on, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy && !erase_on && !prog_zero && erase_req == '0, "R1 abort", {busy, erase_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !window_open, "R1 read mode", busy, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule